// File: doc/BRIEF.md
# Leveled Interrupt Arbiter

The arbiter collects interrupt requests from up to `LEVELS*32` sources, grouped into levels of 32 lines. Each line has a request bit and an enable bit. A request is latched whether or not its line is enabled; the enable only masks it. A single pending output tells the processor that at least one enabled request is waiting. When the processor acknowledges, the arbiter chooses the winning line, clears its request bit, and returns the device number assigned to that line. The device numbers live in a writable table with one entry per line.

Requests are raised through a set vector. Enable state is changed one line at a time through a command port that also reports whether the line stays armed. A small separate decoder is included for two-bit control fields. It applies a keep, set, clear or invert operation to a single flag.

The acknowledge path is a valid/ready pair on both sides. An acknowledge is accepted when `ack_valid` and `ack_ready` are both high. Its result appears on `rsp_valid` one cycle later. The result is held, unchanged, until the consumer raises `rsp_ready`. While a result is waiting and `rsp_ready` is low, `ack_ready` stays low, so a new acknowledge is refused.

Top module: `irq_arbiter`

## Requirements
- R1: `irq_pend` is 1 exactly when some line has both its request bit and its enable bit set. A request on a disabled line is kept but does not raise `irq_pend`.
- R2: Line index = level*32 + bit. The winner is the enabled pending line with the lowest index, so level 0 beats every other level, and within a level bit 0 is served first.
- R3: In the cycle after an accepted acknowledge, `rsp_valid`=1, `rsp_found`=1 and `rsp_dev` holds the table entry of the winning line. From that same edge the winner's request bit reads as clear.
- R4: An acknowledge accepted while no enabled request is pending returns `rsp_found`=0 and `rsp_dev`=0, and it leaves every request bit unchanged.
- R5: When `cmd_valid`=1, `cmd_code` 1 sets the enable bit of line `cmd_line` and code 2 clears it. For both codes `cmd_armed_out` is 1. `cmd_armed_out` is combinational on `cmd_code` and `cmd_armed_in`.
- R6: `cmd_code` 3 (disarm) clears both the enable bit and the request bit of `cmd_line`, and `cmd_armed_out` is 0. Code 0 changes nothing, and `cmd_armed_out` then equals `cmd_armed_in`.
- R7: A bit set in `req_set` is set after the edge, even if in the same cycle an acknowledge or a disarm clears that same line.
- R8: `ack_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_dev` and `rsp_found` hold their values.
- R9: `tbl_we`=1 writes `tbl_wdata` into entry `tbl_addr`. The new value is returned by acknowledges accepted in a later cycle.
- R10: The field decoder takes the bit pair `fld_word[2*fld_sel+1 : 2*fld_sel]` and sets `fld_new` from it: 0 gives `fld_old`, 1 gives 1, 2 gives 0, and 3 gives the inverse of `fld_old`.
- R11: After reset, all request bits, enable bits and table entries are 0, and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | LEVELS*32 | One bit per line; a 1 raises that line's request |
| irq_pend | output | 1 | Some enabled request is waiting |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be accepted |
| rsp_valid | output | 1 | Acknowledge result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_dev | output | DEV_W | Device number of the winning line, or 0 |
| rsp_found | output | 1 | A winning line existed |
| cmd_valid | input | 1 | Apply `cmd_code` to `cmd_line` |
| cmd_line | input | IDX_W | Line index addressed by the command |
| cmd_code | input | 2 | 0 none, 1 enable, 2 disable, 3 disarm |
| cmd_armed_in | input | 1 | Armed state passed through on code 0 |
| cmd_armed_out | output | 1 | Armed state after the command |
| tbl_we | input | 1 | Device table write strobe |
| tbl_addr | input | IDX_W | Device table entry index |
| tbl_wdata | input | DEV_W | Device number to store |
| fld_word | input | 2*FLD_PAIRS | Word holding the two-bit control fields |
| fld_sel | input | SEL_W | Which bit pair to decode |
| fld_old | input | 1 | Current flag value |
| fld_new | output | 1 | Flag value after the field operation |

## Verification
Request, enable and table updates, the pending flag, and an acknowledge result all become visible one clock edge after the inputs that cause them. The bench drives every input on the falling edge, updates its reference model, and compares `irq_pend`, `rsp_valid`, `rsp_dev` and `rsp_found` on the next falling edge. `ack_ready`, `cmd_armed_out` and `fld_new` have no delay: they are compared in the same half cycle in which their inputs are driven, before the clock rises. Directed sequences cover the corner cases: a level-0 bit beating a level-1 bit 0, an acknowledge that collides with a new request on the same line, an acknowledge with nothing pending, a disarm, and a held result.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int LINES_PER_LEVEL = 32;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_ENABLE  = 2'd1,
    CMD_DISABLE = 2'd2,
    CMD_DISARM  = 2'd3
  } irq_cmd_e;

  typedef enum logic [1:0] {
    FLD_KEEP  = 2'd0,
    FLD_SET   = 2'd1,
    FLD_CLEAR = 2'd2,
    FLD_FLIP  = 2'd3
  } fld_op_e;
endpackage

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 7,
  localparam int N     = LEVELS * irq_arb_pkg::LINES_PER_LEVEL
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  localparam int LPL = irq_arb_pkg::LINES_PER_LEVEL;

  logic [LEVELS-1:0] lvl_hit;
  logic [4:0]        lvl_bit [LEVELS];

  // First stage: lowest set bit inside each level
  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    always_comb begin
      lvl_hit[l] = |vec[l*LPL +: LPL];
      lvl_bit[l] = 5'd0;
      for (int b = LPL - 1; b >= 0; b--) begin
        if (vec[l*LPL + b]) lvl_bit[l] = 5'(b);
      end
    end
  end

  // Second stage: lowest level that has any bit
  always_comb begin
    found = |lvl_hit;
    idx   = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (lvl_hit[l]) idx = IDX_W'(l * LPL) | IDX_W'(lvl_bit[l]);
    end
  end
endmodule

// File: rtl/irq_dev_table.sv
`timescale 1ns/1ps
module irq_dev_table #(
  parameter int N     = 128,
  parameter int IDX_W = 7,
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DEV_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DEV_W-1:0] rdata
);
  logic [DEV_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < N)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < N) ? mem[raddr] : '0;
endmodule

// File: rtl/irq_field_dec.sv
`timescale 1ns/1ps
module irq_field_dec #(
  parameter int PAIRS = 4,
  parameter int SEL_W = 2
) (
  input  logic [2*PAIRS-1:0] word,
  input  logic [SEL_W-1:0]   sel,
  input  logic               old_bit,
  output logic               new_bit
);
  import irq_arb_pkg::*;

  logic [1:0] pair [PAIRS];
  fld_op_e    op;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair[p] = word[2*p +: 2];
  end

  always_comb begin
    op = fld_op_e'((int'(sel) < PAIRS) ? pair[sel] : 2'b00);
    unique case (op)
      FLD_SET:   new_bit = 1'b1;
      FLD_CLEAR: new_bit = 1'b0;
      FLD_FLIP:  new_bit = ~old_bit;
      default:   new_bit = old_bit;
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int  LEVELS    = 4,
  parameter int  DEV_W     = 8,
  parameter int  FLD_PAIRS = 4,
  localparam int N         = LEVELS * irq_arb_pkg::LINES_PER_LEVEL,
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int IDX_W     = LVL_W + 5,
  localparam int SEL_W     = (FLD_PAIRS > 1) ? $clog2(FLD_PAIRS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req_set,
  output logic                   irq_pend,
  input  logic                   ack_valid,
  output logic                   ack_ready,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DEV_W-1:0]       rsp_dev,
  output logic                   rsp_found,
  input  logic                   cmd_valid,
  input  logic [IDX_W-1:0]       cmd_line,
  input  logic [1:0]             cmd_code,
  input  logic                   cmd_armed_in,
  output logic                   cmd_armed_out,
  input  logic                   tbl_we,
  input  logic [IDX_W-1:0]       tbl_addr,
  input  logic [DEV_W-1:0]       tbl_wdata,
  input  logic [2*FLD_PAIRS-1:0] fld_word,
  input  logic [SEL_W-1:0]       fld_sel,
  input  logic                   fld_old,
  output logic                   fld_new
);
  import irq_arb_pkg::*;

  logic [N-1:0]     req_q, enb_q, req_d, enb_d;
  logic [N-1:0]     masked, clr_mask, line_mask, below_win;
  logic             win_found, ack_fire;
  logic [IDX_W-1:0] win_idx;
  logic [DEV_W-1:0] win_dev;
  irq_cmd_e         cmd_e;

  assign masked   = req_q & enb_q;
  assign irq_pend = |masked;

  irq_prio_enc #(.LEVELS(LEVELS), .IDX_W(IDX_W)) i_prio (
    .vec(masked), .found(win_found), .idx(win_idx)
  );

  irq_dev_table #(.N(N), .IDX_W(IDX_W), .DEV_W(DEV_W)) i_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr),
    .wdata(tbl_wdata), .raddr(win_idx), .rdata(win_dev)
  );

  irq_field_dec #(.PAIRS(FLD_PAIRS), .SEL_W(SEL_W)) i_field (
    .word(fld_word), .sel(fld_sel), .old_bit(fld_old), .new_bit(fld_new)
  );

  // Acknowledge handshake
  assign ack_ready = !rsp_valid || rsp_ready;
  assign ack_fire  = ack_valid && ack_ready;

  // Per-line commands
  assign cmd_e     = irq_cmd_e'(cmd_code);
  assign line_mask = N'(1) << cmd_line;

  always_comb begin
    unique case (cmd_e)
      CMD_ENABLE, CMD_DISABLE: cmd_armed_out = 1'b1;
      CMD_DISARM:              cmd_armed_out = 1'b0;
      default:                 cmd_armed_out = cmd_armed_in;
    endcase
  end

  always_comb begin
    clr_mask = '0;
    if (ack_fire && win_found) clr_mask[win_idx] = 1'b1;
    if (cmd_valid && cmd_e == CMD_DISARM) clr_mask = clr_mask | line_mask;
    // new requests win over any clear in the same cycle
    req_d = (req_q & ~clr_mask) | req_set;
  end

  always_comb begin
    enb_d = enb_q;
    if (cmd_valid) begin
      unique case (cmd_e)
        CMD_ENABLE:              enb_d = enb_q | line_mask;
        CMD_DISABLE, CMD_DISARM: enb_d = enb_q & ~line_mask;
        default:                 enb_d = enb_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= '0;
      enb_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_dev   <= '0;
    end else begin
      req_q <= req_d;
      enb_q <= enb_d;
      if (ack_fire) begin
        rsp_valid <= 1'b1;
        rsp_found <= win_found;
        rsp_dev   <= win_found ? win_dev : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // Assertions
  assign below_win = (N'(1) << win_idx) - N'(1);

  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    win_found |-> (masked[win_idx] && ((masked & below_win) == '0))); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && win_found && !req_set[win_idx]) |=> !req_q[$past(win_idx)]); // R3

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> (rsp_dev == '0)); // R4

  AST_ENB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'd1) |=> enb_q[$past(cmd_line)]); // R5

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'd3 && !req_set[cmd_line])
    |=> (!req_q[$past(cmd_line)] && !enb_q[$past(cmd_line)])); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_set) |=> ((req_q & $past(req_set)) == $past(req_set))); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready)
    |=> (rsp_valid && $stable(rsp_dev) && $stable(rsp_found))); // R8
endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;
  localparam int N = 128, IDX_W = 7, DEV_W = 8, PAIRS = 4, SEL_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_set;
  logic irq_pend, ack_valid, ack_ready, rsp_valid, rsp_ready, rsp_found;
  logic [DEV_W-1:0] rsp_dev;
  logic cmd_valid, cmd_armed_in, cmd_armed_out;
  logic [IDX_W-1:0] cmd_line, tbl_addr;
  logic [1:0] cmd_code;
  logic tbl_we;
  logic [DEV_W-1:0] tbl_wdata;
  logic [2*PAIRS-1:0] fld_word;
  logic [SEL_W-1:0] fld_sel;
  logic fld_old, fld_new;

  always #2.5 clk = ~clk;

  irq_arbiter i_irq_arbiter (.*);

  // reference model
  logic [N-1:0] req_m = '0, enb_m = '0;
  logic [DEV_W-1:0] tbl_m [N];
  logic rv_m = 1'b0, rf_m = 1'b0;
  logic [DEV_W-1:0] rd_m = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string req, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): got %0h expected %0h", req, tag, got, exp);
    end
  endtask

  function automatic int pick_winner();
    for (int i = 0; i < N; i++) if (req_m[i] && enb_m[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_field(logic [2*PAIRS-1:0] w, logic [SEL_W-1:0] s, logic o);
    logic [1:0] c = w[2*s +: 2];
    case (c)
      2'd1: return 1'b1;
      2'd2: return 1'b0;
      2'd3: return ~o;
      default: return o;
    endcase
  endfunction

  task automatic idle();
    req_set = '0; ack_valid = 0; rsp_ready = 1; cmd_valid = 0; cmd_line = '0;
    cmd_code = 2'd0; cmd_armed_in = 0; tbl_we = 0; tbl_addr = '0; tbl_wdata = '0;
    fld_word = '0; fld_sel = '0; fld_old = 0;
  endtask

  // inputs are already driven at a falling edge
  task automatic cycle(string tag);
    int w;
    logic acc, ea;
    #0.5;
    ea = (cmd_code == 2'd3) ? 1'b0 : (cmd_code != 2'd0) ? 1'b1 : cmd_armed_in;
    chk((cmd_code == 2'd1 || cmd_code == 2'd2) ? "R5" : "R6", tag, 32'(cmd_armed_out), 32'(ea));
    chk("R10", tag, 32'(fld_new), 32'(exp_field(fld_word, fld_sel, fld_old)));
    chk("R8", tag, 32'(ack_ready), 32'(!rv_m || rsp_ready));
    acc = ack_valid && (!rv_m || rsp_ready);
    w = pick_winner();
    if (acc) begin
      rv_m = 1'b1; rf_m = (w >= 0); rd_m = (w >= 0) ? tbl_m[w] : '0;
      if (w >= 0) req_m[w] = 1'b0;
    end else if (rsp_ready) rv_m = 1'b0;
    if (cmd_valid) begin
      case (cmd_code)
        2'd1: enb_m[cmd_line] = 1'b1;
        2'd2: enb_m[cmd_line] = 1'b0;
        2'd3: begin enb_m[cmd_line] = 1'b0; req_m[cmd_line] = 1'b0; end
        default: ;
      endcase
    end
    req_m = req_m | req_set;  // R7: set beats a same-cycle clear
    if (tbl_we) tbl_m[tbl_addr] = tbl_wdata;  // R9
    @(posedge clk); @(negedge clk);
    chk("R1", tag, 32'(irq_pend), 32'(|(req_m & enb_m)));
    chk("R8", tag, 32'(rsp_valid), 32'(rv_m));
    if (rv_m) begin
      chk("R4", tag, 32'(rsp_found), 32'(rf_m));
      chk("R3", tag, 32'(rsp_dev), 32'(rd_m));
    end
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) tbl_m[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk("R11", "reset", 32'(irq_pend), 32'd0);
    chk("R11", "reset", 32'(rsp_valid), 32'd0);
    chk("R11", "reset", 32'(ack_ready), 32'd1);
    ack_valid = 1; cycle("R11 ack after reset returns 0");

    // R1: request on a disabled line is masked, then enabled
    req_set[5] = 1; cycle("R1 masked request");
    cmd_valid = 1; cmd_line = 7'd5; cmd_code = 2'd1; cycle("R1 enable line 5");

    // R9: table writes
    tbl_we = 1; tbl_addr = 7'd5;  tbl_wdata = 8'hA5; cycle("R9 write 5");
    tbl_we = 1; tbl_addr = 7'd40; tbl_wdata = 8'h3C; cycle("R9 write 40");
    tbl_we = 1; tbl_addr = 7'd31; tbl_wdata = 8'h77; cycle("R9 write 31");
    tbl_we = 1; tbl_addr = 7'd32; tbl_wdata = 8'h11; cycle("R9 write 32");

    // R2: level0 bit31 beats level1 bit0 and bit8
    cmd_valid = 1; cmd_line = 7'd5; cmd_code = 2'd2; req_set[31] = 1; req_set[32] = 1; req_set[40] = 1;
    cycle("R2 setup");
    cmd_valid = 1; cmd_line = 7'd31; cmd_code = 2'd1; cycle("R2 enable 31");
    cmd_valid = 1; cmd_line = 7'd32; cmd_code = 2'd1; cycle("R2 enable 32");
    cmd_valid = 1; cmd_line = 7'd40; cmd_code = 2'd1; cycle("R2 enable 40");
    ack_valid = 1; cycle("R2 level 0 wins");
    ack_valid = 1; cycle("R2 level 1 bit 0 next");

    // R7: collision of acknowledge clear and new request on the winner
    ack_valid = 1; req_set[40] = 1; cycle("R7 set during ack");
    ack_valid = 1; cycle("R7 request survived");

    // R4: nothing pending
    ack_valid = 1; cycle("R4 empty ack");
    ack_valid = 1; cycle("R4 empty ack again");

    // R6: disarm clears request and enable
    req_set[40] = 1; cycle("R6 raise 40");
    cmd_valid = 1; cmd_line = 7'd40; cmd_code = 2'd3; cycle("R6 disarm 40");
    cmd_valid = 1; cmd_line = 7'd40; cmd_code = 2'd1; cycle("R6 re-enable, no request");
    cmd_armed_in = 1; cycle("R6 code 0 passes armed");

    // R8: back-pressure holds the result
    req_set[31] = 1; cycle("R8 raise 31");
    ack_valid = 1; rsp_ready = 0; cycle("R8 accepted");
    ack_valid = 1; rsp_ready = 0; cycle("R8 refused, held");
    ack_valid = 1; rsp_ready = 0; cycle("R8 still held");
    rsp_ready = 1; cycle("R8 drained");

    // R10: every field code with both old values
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 2; o++) begin
        fld_sel = 2'd2; fld_word = 8'(c << 4); fld_old = o[0];
        cycle("R10 directed");
      end
    end

    // random mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 3 == 0) req_set[($urandom % 2) ? ($urandom % 16) : ($urandom % N)] = 1'b1;
      cmd_valid = ($urandom % 3 == 0);
      cmd_line = IDX_W'(($urandom % 2) ? ($urandom % 16) : ($urandom % N));
      cmd_code = 2'($urandom % 4);
      cmd_armed_in = 1'($urandom);
      ack_valid = ($urandom % 3 == 0);
      rsp_ready = ($urandom % 4 != 0);
      tbl_we = ($urandom % 8 == 0);
      tbl_addr = IDX_W'(($urandom % 2) ? ($urandom % 16) : ($urandom % N));
      tbl_wdata = DEV_W'($urandom);
      fld_word = 8'($urandom); fld_sel = 2'($urandom); fld_old = 1'($urandom);
      cycle("random");
    end
    finish_run();
  end
endmodule